// File: doc/BRIEF.md
# Core Module Control Register Bank

This block is the control and identification register bank of a processor core module. A host reaches it over a simple 32-bit register bus that carries a word offset, a read strobe, a write strobe and write data; read data is returned combinationally in the same cycle as the read strobe. The bank holds fixed identity and status words, two oscillator setting registers guarded by a 16-bit unlock key, a control register that drives an LED line, a boot remap line and a one-cycle system reset request, and memory setup words. It also holds two flag registers that have separate set and clear addresses, a free-running reference counter, and a read-only window onto a 128-byte presence-detect table.

An access to a word offset that has no meaning for that direction returns zero and raises an error flag for that cycle. Such an access leaves all state unchanged. The reference counter advances once every `REF_DIV` system clocks, so the default divider of 2 yields a 24 MHz rate from a 48 MHz clock. The `MEM_MB` parameter selects the memory size code that is folded into the SDRAM register's reset value.

Top module: `cm_ctrl_regs`

## Requirements
- R1: Word 0 reads 0x411A3001, word 1 reads 0 and word 4 reads 0x00100000. Words 32 to 35 read 0, and writes to them are accepted with no error and no effect.
- R2: The lock word (5) keeps only the low 16 bits of a write. While it holds 0xA05F it reads 0x0001A05F (bit 16 set means unlocked); otherwise it reads the stored 16-bit value.
- R3: Writes to the oscillator word (2) and the auxiliary oscillator word (7) update them only while the lock holds 0xA05F; at any other time those words keep their value.
- R4: The control word (3) keeps only bits 0 and 2. Bit 0 drives `led_o`, and bit 2 drives `remap_o` (0 = boot flash at address zero, 1 = RAM at address zero). All other bits read 0.
- R5: A write to word 3 with bit 3 set drives `sys_rst_req_o` high for exactly the one cycle after the write edge; bit 3 always reads 0.
- R6: A write to word 12 ORs the data into the flags; a write to word 13 clears the bits that are set in the data. Words 14 and 15 do the same for the non-volatile flags. Words 12 and 14 read the current values.
- R7: The SDRAM word (8) and the init word (9) store and return all 32 bits.
- R8: After reset: oscillator 0x01000048, auxiliary 0x0007FEFF, init 0x00000112, SDRAM 0x00011122 ORed with a size code (0x10 for 256 MB or more, 0x0C for 128, 0x08 for 64, 0x04 for 32, else 0), lock 0, control 0, both flag registers 0, and all three outputs low.
- R9: Word 10 reads floor(N / REF_DIV) mod 2^32, where N is the number of clock edges since reset was released.
- R10: Words 0x40 to 0x5F (byte offsets 0x100 to 0x17F) read the table byte for index w (the word offset), zero-extended, where byte(w) = ((w * 29) mod 256) XOR 0xA5. Words 0x60 to 0x7F read 0.
- R11: A read of a word without read meaning (6, 11, 13, 15, 16 to 31, 36 to 63) or a write to a word without write meaning (0, 1, 4, 6, 10, 11, 16 to 31, 36 to 127) returns 0 on `bus_rdata`, raises `bus_err` in that same cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Word offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| bus_err | output | 1 | High for the cycle of an access that has no meaning at that offset |
| led_o | output | 1 | LED drive from control bit 0 |
| remap_o | output | 1 | Memory remap select from control bit 2 |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Two functions can meet in one cycle when a single control write sets both the remap bit and the reset bit. The remap level and the reset pulse must then appear together after the same edge, and the pulse must drop one cycle later while remap stays high. The bench issues that write and samples both outputs in the following two cycles. A read of the reference counter can also coincide with a prescaler rollover; the bench judges it against its own edge count, which pins the read to the value held before that edge.

// File: rtl/cm_ctrl_pkg.sv
package cm_ctrl_pkg;

    localparam int WORD_AW   = 7;
    localparam int DATA_W    = 32;
    localparam int SPD_DEPTH = 128;
    localparam int KEY_W     = 16;

    localparam logic [DATA_W-1:0] MODULE_ID   = 32'h411A_3001;
    localparam logic [DATA_W-1:0] STATUS_WORD = 32'h0010_0000;
    localparam logic [KEY_W-1:0]  UNLOCK_KEY  = 16'hA05F;
    localparam logic [DATA_W-1:0] OSC_RST     = 32'h0100_0048;
    localparam logic [DATA_W-1:0] AUX_RST     = 32'h0007_FEFF;
    localparam logic [DATA_W-1:0] INIT_RST    = 32'h0000_0112;
    localparam logic [DATA_W-1:0] SDRAM_BASE  = 32'h0001_1122;

    typedef enum logic [4:0] {
        SEL_ID, SEL_ZERO, SEL_OSC, SEL_CTRL, SEL_STAT, SEL_LOCK,
        SEL_AUX, SEL_SDRAM, SEL_INIT, SEL_REF, SEL_FLG_SET, SEL_FLG_CLR,
        SEL_NV_SET, SEL_NV_CLR, SEL_VOLT, SEL_SPD, SEL_SPD_BLANK, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
    } acc_perm_t;

    function automatic reg_sel_e decode_word(input logic [WORD_AW-1:0] w);
        reg_sel_e s;
        if (w >= 7'h60)      s = SEL_SPD_BLANK;
        else if (w >= 7'h40) s = SEL_SPD;
        else begin
            case (w)
                7'd0:  s = SEL_ID;
                7'd1:  s = SEL_ZERO;
                7'd2:  s = SEL_OSC;
                7'd3:  s = SEL_CTRL;
                7'd4:  s = SEL_STAT;
                7'd5:  s = SEL_LOCK;
                7'd7:  s = SEL_AUX;
                7'd8:  s = SEL_SDRAM;
                7'd9:  s = SEL_INIT;
                7'd10: s = SEL_REF;
                7'd12: s = SEL_FLG_SET;
                7'd13: s = SEL_FLG_CLR;
                7'd14: s = SEL_NV_SET;
                7'd15: s = SEL_NV_CLR;
                7'd32, 7'd33, 7'd34, 7'd35: s = SEL_VOLT;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic acc_perm_t perm_of(input reg_sel_e s);
        acc_perm_t p;
        case (s)
            SEL_ID, SEL_ZERO, SEL_STAT, SEL_REF, SEL_SPD, SEL_SPD_BLANK:
                p = '{rd_ok: 1'b1, wr_ok: 1'b0};
            SEL_FLG_CLR, SEL_NV_CLR:
                p = '{rd_ok: 1'b0, wr_ok: 1'b1};
            SEL_NONE:
                p = '{rd_ok: 1'b0, wr_ok: 1'b0};
            default:
                p = '{rd_ok: 1'b1, wr_ok: 1'b1};
        endcase
        return p;
    endfunction

    function automatic logic [DATA_W-1:0] size_code(input int mb);
        if (mb >= 256)     return 32'h10;
        else if (mb >= 128) return 32'h0C;
        else if (mb >= 64)  return 32'h08;
        else if (mb >= 32)  return 32'h04;
        else                return 32'h00;
    endfunction

    function automatic logic [7:0] spd_byte(input int i);
        logic [7:0] t;
        t = 8'(i * 29);
        return t ^ 8'hA5;
    endfunction

endpackage

// File: rtl/cm_spd_rom.sv
module cm_spd_rom
    import cm_ctrl_pkg::*;
#(
    parameter int DEPTH = SPD_DEPTH
) (
    input  logic [$clog2(DEPTH)-1:0] idx,
    output logic [7:0]               data_o
);
    logic [7:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = spd_byte(i);
    end

    assign data_o = table_q[idx];
endmodule

// File: rtl/cm_refcount.sv
module cm_refcount #(
    parameter int DIV = 2,
    parameter int W   = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            count <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
            count <= count + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/cm_setclr_reg.sv
module cm_setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (set_en) q <= q | wdata;
        else if (clr_en) q <= q & ~wdata;
    end
endmodule

// File: rtl/cm_ctrl_regs.sv
module cm_ctrl_regs
    import cm_ctrl_pkg::*;
#(
    parameter int REF_DIV = 2,
    parameter int MEM_MB  = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WORD_AW-1:0]  bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_err,
    output logic                led_o,
    output logic                remap_o,
    output logic                sys_rst_req_o
);
    localparam logic [DATA_W-1:0] SDRAM_RST = SDRAM_BASE | size_code(MEM_MB);
    localparam int NFLAG = 2;

    reg_sel_e   sel;
    acc_perm_t  perm;
    logic       wr_go;
    logic       unlocked;

    logic [DATA_W-1:0] osc_q, aux_q, sdram_q, init_q, ref_cnt;
    logic [KEY_W-1:0]  lock_q;
    logic              led_q, remap_q, rst_req_q;
    logic [7:0]        spd_data;

    logic [NFLAG-1:0]  fl_set, fl_clr;
    logic [DATA_W-1:0] fl_q [NFLAG];
    logic [DATA_W-1:0] flags_q;

    assign sel      = decode_word(bus_addr);
    assign perm     = perm_of(sel);
    assign wr_go    = bus_wr & perm.wr_ok;
    assign unlocked = (lock_q == UNLOCK_KEY);
    assign bus_err  = (bus_rd & ~perm.rd_ok) | (bus_wr & ~perm.wr_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_q     <= OSC_RST;
            aux_q     <= AUX_RST;
            sdram_q   <= SDRAM_RST;
            init_q    <= INIT_RST;
            lock_q    <= '0;
            led_q     <= 1'b0;
            remap_q   <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= wr_go && (sel == SEL_CTRL) && bus_wdata[3];
            if (wr_go) begin
                case (sel)
                    SEL_OSC:   if (unlocked) osc_q <= bus_wdata;
                    SEL_AUX:   if (unlocked) aux_q <= bus_wdata;
                    SEL_LOCK:  lock_q  <= bus_wdata[KEY_W-1:0];
                    SEL_SDRAM: sdram_q <= bus_wdata;
                    SEL_INIT:  init_q  <= bus_wdata;
                    SEL_CTRL: begin
                        led_q   <= bus_wdata[0];
                        remap_q <= bus_wdata[2];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign fl_set[0] = wr_go && (sel == SEL_FLG_SET);
    assign fl_clr[0] = wr_go && (sel == SEL_FLG_CLR);
    assign fl_set[1] = wr_go && (sel == SEL_NV_SET);
    assign fl_clr[1] = wr_go && (sel == SEL_NV_CLR);

    for (genvar g = 0; g < NFLAG; g++) begin : g_flags
        cm_setclr_reg #(.W(DATA_W)) u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_en (fl_set[g]),
            .clr_en (fl_clr[g]),
            .wdata  (bus_wdata),
            .q      (fl_q[g])
        );
    end
    assign flags_q = fl_q[0];

    cm_refcount #(.DIV(REF_DIV), .W(DATA_W)) u_ref (
        .clk   (clk),
        .rst   (rst),
        .count (ref_cnt)
    );

    cm_spd_rom #(.DEPTH(SPD_DEPTH)) u_spd (
        .idx    (bus_addr),
        .data_o (spd_data)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && perm.rd_ok) begin
            case (sel)
                SEL_ID:      bus_rdata = MODULE_ID;
                SEL_STAT:    bus_rdata = STATUS_WORD;
                SEL_OSC:     bus_rdata = osc_q;
                SEL_AUX:     bus_rdata = aux_q;
                SEL_CTRL:    bus_rdata = {29'b0, remap_q, 1'b0, led_q};
                SEL_LOCK:    bus_rdata = {15'b0, unlocked, lock_q};
                SEL_SDRAM:   bus_rdata = sdram_q;
                SEL_INIT:    bus_rdata = init_q;
                SEL_REF:     bus_rdata = ref_cnt;
                SEL_FLG_SET: bus_rdata = fl_q[0];
                SEL_NV_SET:  bus_rdata = fl_q[1];
                SEL_SPD:     bus_rdata = {24'b0, spd_data};
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign led_o         = led_q;
    assign remap_o       = remap_q;
    assign sys_rst_req_o = rst_req_q;
endmodule

// File: rtl/cm_ctrl_regs_chk.sv
module cm_ctrl_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic [6:0]  bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic        bus_err,
    input logic        remap_o,
    input logic        sys_rst_req_o,
    input logic [31:0] osc_q,
    input logic [15:0] lock_q,
    input logic [31:0] flags_q,
    input logic [31:0] ref_cnt
);
    a_r3_osc_locked: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 7'd2 && lock_q != 16'hA05F) |=> $stable(osc_q));

    a_r4_remap_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 7'd3) |=> $stable(remap_o));

    a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req_o |=> !sys_rst_req_o);

    a_r5_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_req_o) |-> $past(bus_wr && bus_addr == 7'd3 && bus_wdata[3]));

    a_r6_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 7'd13) |=> ((flags_q & $past(bus_wdata)) == 32'd0));

    a_r9_ref_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ref_cnt == $past(ref_cnt) || ref_cnt == $past(ref_cnt) + 32'd1));

    a_r11_err_needs_access: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_rd || bus_wr));

    a_r11_err_no_change: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_err) |=> ($stable(osc_q) && $stable(lock_q) && $stable(flags_q)));
endmodule

bind cm_ctrl_regs cm_ctrl_regs_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_err       (bus_err),
    .remap_o       (remap_o),
    .sys_rst_req_o (sys_rst_req_o),
    .osc_q         (osc_q),
    .lock_q        (lock_q),
    .flags_q       (flags_q),
    .ref_cnt       (ref_cnt)
);

// File: tb/test_cm_ctrl_regs.sv
module test_cm_ctrl_regs;
    localparam int REF_DIV = 2;
    localparam int MEM_MB  = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, led_o, remap_o, sys_rst_req_o;

    int n_chk = 0;
    int n_fail = 0;
    int edges = 0;

    logic [31:0] m_osc, m_aux, m_sdram, m_init, m_flg, m_nv;
    logic [15:0] m_lock;
    logic        m_led, m_remap;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    cm_ctrl_regs #(.REF_DIV(REF_DIV), .MEM_MB(MEM_MB)) i_cm_ctrl_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .led_o(led_o), .remap_o(remap_o),
        .sys_rst_req_o(sys_rst_req_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic bit rd_ok(input int a);
        if (a >= 64) return 1'b1;
        if (a <= 5 || (a >= 7 && a <= 10) || a == 12 || a == 14 || (a >= 32 && a <= 35))
            return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit wr_ok(input int a);
        return (a == 2 || a == 3 || a == 5 || a == 7 || a == 8 || a == 9 ||
                (a >= 12 && a <= 15) || (a >= 32 && a <= 35));
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0, 1, 4, 32, 33, 34, 35: return "R1";
            5:  return "R2";
            2, 7: return "R3";
            3:  return "R4";
            8, 9: return "R7";
            10: return "R9";
            12, 14: return "R6";
            default: return (a >= 64) ? "R10" : "R11";
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        logic [7:0] t;
        if (!rd_ok(a)) return 32'd0;
        if (a >= 96) return 32'd0;
        if (a >= 64) begin
            t = 8'(a * 29);
            return {24'd0, t ^ 8'hA5};
        end
        case (a)
            0:  return 32'h411A3001;
            4:  return 32'h00100000;
            2:  return m_osc;
            3:  return {29'd0, m_remap, 1'b0, m_led};
            5:  return (m_lock == 16'hA05F) ? 32'h0001A05F : {16'd0, m_lock};
            7:  return m_aux;
            8:  return m_sdram;
            9:  return m_init;
            10: return 32'(edges / REF_DIV);
            12: return m_flg;
            14: return m_nv;
            default: return 32'd0;
        endcase
    endfunction

    task automatic do_read(input int a);
        @(negedge clk);
        bus_addr = 7'(a); bus_rd = 1'b1; bus_wr = 1'b0;
        #1;
        check(tag_of(a), bus_rdata, exp_read(a));
        check(rd_ok(a) ? tag_of(a) : "R11", {31'd0, bus_err}, {31'd0, !rd_ok(a)});
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b0;
        bus_addr = 7'(a); bus_wr = 1'b1; bus_wdata = d;
        #1;
        check("R11", {31'd0, bus_err}, {31'd0, !wr_ok(a)});
        case (a)
            2:  if (m_lock == 16'hA05F) m_osc = d;
            7:  if (m_lock == 16'hA05F) m_aux = d;
            3:  begin m_led = d[0]; m_remap = d[2]; end
            5:  m_lock = d[15:0];
            8:  m_sdram = d;
            9:  m_init = d;
            12: m_flg = m_flg | d;
            13: m_flg = m_flg & ~d;
            14: m_nv = m_nv | d;
            15: m_nv = m_nv & ~d;
            default: ;
        endcase
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic sweep();
        for (int a = 0; a < 128; a++) do_read(a);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_init = 32'h00000112;
        m_sdram = 32'h0001112E; m_flg = '0; m_nv = '0; m_lock = '0;
        m_led = 1'b0; m_remap = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R8: outputs after reset
        check("R8", {29'd0, led_o, remap_o, sys_rst_req_o}, 32'd0);
        sweep();   // R8 reset values, R1, R10, R11 reads

        // R3: locked oscillator writes are dropped
        do_write(2, 32'hDEAD0001);
        do_write(7, 32'hDEAD0002);
        do_read(2); do_read(7);
        // R2: key stored from low half, unlocked flag in bit 16
        do_write(5, 32'h1234A05F);
        do_read(5);
        do_write(2, 32'hCAFE0010);
        do_write(7, 32'hCAFE0020);
        do_read(2); do_read(7);
        do_write(5, 32'hFFFF1234);
        do_read(5);
        do_write(2, 32'h0BAD0BAD);
        do_read(2);

        // R4 / R5: remap and reset request from one write
        do_write(3, 32'hFFFF_FFFF);
        check("R5", {31'd0, sys_rst_req_o}, 32'd1);
        check("R4", {30'd0, led_o, remap_o}, 32'd3);
        @(negedge clk); #1;
        check("R5", {31'd0, sys_rst_req_o}, 32'd0);
        check("R4", {31'd0, remap_o}, 32'd1);
        do_read(3);
        do_write(3, 32'h0000_0008);
        check("R5", {31'd0, sys_rst_req_o}, 32'd1);
        check("R4", {30'd0, led_o, remap_o}, 32'd0);
        do_write(3, 32'h0000_0004);
        check("R5", {31'd0, sys_rst_req_o}, 32'd0);
        do_read(3);

        // R6: set/clear flags
        do_write(12, 32'h0000F0F0);
        do_write(12, 32'h00000F00);
        do_write(13, 32'h000000F0);
        do_write(14, 32'h80000001);
        do_write(15, 32'h00000001);
        do_read(12); do_read(14);

        // R7: full-width memory words
        do_write(8, 32'hA5A5_5A5A);
        do_write(9, 32'h1357_9BDF);
        do_read(8); do_read(9);

        // R1 / R11: voltage no-ops and every non-writable word
        for (int a = 32; a < 36; a++) do_write(a, 32'hFFFF_FFFF);
        for (int a = 0; a < 128; a++)
            if (!wr_ok(a)) do_write(a, 32'hFFFF_FFFF);
        sweep();

        // R9: counter at several distances from reset
        for (int k = 0; k < 6; k++) begin
            repeat (k * 37 + 1) @(negedge clk);
            do_read(10);
        end
        @(negedge clk);
        bus_rd = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule